// File: doc/BRIEF.md
# Compare-Match Timer with Output Pin

This block is a 10-bit up-counting timer with two comparators, two interrupt request flags and one output pin. Comparator A checks the full count against a 10-bit compare value. Comparator P checks only the top three counter bits, so it sets the period in coarse steps of 128 counts. A clear-select input chooses which comparator restarts the counter. That choice also decides which flags can be raised.

Each A match can drive the pin low, drive it high, toggle it, or leave it unchanged. When the enable input rises, the pin is first loaded with a chosen starting level. Flags hold their value until software clears them with a write-one pulse.

A 2-bit mode input is decoded. Only the compare-match-output mode is implemented. Any other mode value freezes the timer.

Top module: `cmt_timer`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `count` is 0, `flag_a` is 0, `flag_p` is 0 and `pin_out` is 0.
- R2: While `run` is 0, `count` and `pin_out` keep their values from one cycle to the next.
- R3: Only `mode` = 2'b00 is active. With any other value, `count` holds and neither flag is set by a match.
- R4: With `clr_sel` = 0, a P match occurs in an active cycle where `count` equals {`cmp_p`, 7'b0}. If `cmp_p` is zero, the P match occurs at `count` = 10'h3FF instead. On a P match, `count` returns to 0 in the next cycle and `flag_p` is set. In every other active cycle, `count` increments by one.
- R5: With `clr_sel` = 1, an active cycle where `count` equals a nonzero `cmp_a` sends `count` back to 0 in the next cycle. In this setting `flag_p` is never set, even when {`cmp_p`, 7'b0} is below `cmp_a`.
- R6: When `cmp_a` is zero, no A match occurs. The counter wraps from 10'h3FF to 0, and `flag_a` is not set.
- R7: An A match is an active cycle where `count` equals a nonzero `cmp_a`, under either `clr_sel` setting. It sets `flag_a` in the next cycle. It also drives `pin_out` in the next cycle according to `pin_act`: 2'b00 no change, 2'b01 low, 2'b10 high, 2'b11 toggle. A P match never changes `pin_out`.
- R8: In a cycle where `run` is 1 and was 0 in the previous cycle, `pin_out` takes `init_lvl` in the next cycle. This load takes priority over an A-match action in the same cycle.
- R9: A flag stays set until a cycle with `flag_clr[0]` = 1 (for `flag_a`) or `flag_clr[1]` = 1 (for `flag_p`) clears it. A match in that same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enable; counter advances while high |
| mode | input | 2 | Operating mode; 2'b00 = compare-match output |
| clr_sel | input | 1 | 0: clear on P match, 1: clear on A match |
| pin_act | input | 2 | Pin action on an A match |
| init_lvl | input | 1 | Pin level loaded when run rises |
| cmp_a | input | 10 | Full-width compare value A |
| cmp_p | input | 3 | Coarse period value, compared with count[9:7] |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 clears flag_a, bit 1 clears flag_p |
| count | output | 10 | Current counter value |
| flag_a | output | 1 | Sticky A-match request flag |
| flag_p | output | 1 | Sticky P-match request flag |
| pin_out | output | 1 | Timer output pin |

## Verification
The bench targets the zero compare values, where a design that treats zero as an ordinary match would clear at count 0 and raise a flag on every cycle instead of running to 10'h3FF. It sets `cmp_p` below `cmp_a` with `clr_sel` high, which catches a P flag that leaks through in that setting. It steps through all four pin actions and re-enables the timer with both starting levels, which catches a wrong encoding, or an enable load that is lost or loses priority to the match action. Random stretches mix flag clears with matches to expose a clear that wrongly beats a set, and non-zero mode values to expose a timer that keeps counting.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        MODE_CMP_OUT = 2'b00,
        MODE_RSVD1   = 2'b01,
        MODE_RSVD2   = 2'b10,
        MODE_RSVD3   = 2'b11
    } mode_e;

endpackage

// File: rtl/cmt_match.sv
module cmt_match #(
    parameter int CW = 10,
    parameter int PW = 3
) (
    input  logic          active,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp_a,
    input  logic [PW-1:0] cmp_p,
    output logic          a_hit,
    output logic          p_hit
);
    localparam int LW = CW - PW;

    logic [CW-1:0] p_target;

    always_comb begin
        // zero coarse value means a full-scale period
        if (cmp_p == '0) p_target = '1;
        else             p_target = {cmp_p, {LW{1'b0}}};
        a_hit = active && (cmp_a != '0) && (cnt == cmp_a);
        p_hit = active && (cnt == p_target);
    end
endmodule

// File: rtl/cmt_pinctl.sv
module cmt_pinctl
    import cmt_pkg::*;
(
    input  logic     pin_q,
    input  pin_act_e act,
    input  logic     a_evt,
    input  logic     rise,
    input  logic     init_lvl,
    output logic     pin_d
);
    always_comb begin
        pin_d = pin_q;
        if (rise) begin
            pin_d = init_lvl;
        end else if (a_evt) begin
            unique case (act)
                ACT_NONE:   pin_d = pin_q;
                ACT_LOW:    pin_d = 1'b0;
                ACT_HIGH:   pin_d = 1'b1;
                ACT_TOGGLE: pin_d = ~pin_q;
                default:    pin_d = pin_q;
            endcase
        end
    end
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int CW = 10,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [1:0]    mode,
    input  logic          clr_sel,
    input  logic [1:0]    pin_act,
    input  logic          init_lvl,
    input  logic [CW-1:0] cmp_a,
    input  logic [PW-1:0] cmp_p,
    input  logic [1:0]    flag_clr,
    output logic [CW-1:0] count,
    output logic          flag_a,
    output logic          flag_p,
    output logic          pin_out
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fa;
        logic          fp;
        logic          pin;
        logic          run;
    } state_t;

    state_t st_d, st_q;
    logic   active, a_hit, p_hit, rise, pin_nx, restart;

    assign active = run && (mode_e'(mode) == MODE_CMP_OUT);
    assign rise   = run && !st_q.run;

    cmt_match #(.CW(CW), .PW(PW)) u_match (
        .active (active),
        .cnt    (st_q.cnt),
        .cmp_a  (cmp_a),
        .cmp_p  (cmp_p),
        .a_hit  (a_hit),
        .p_hit  (p_hit)
    );

    cmt_pinctl u_pin (
        .pin_q    (st_q.pin),
        .act      (pin_act_e'(pin_act)),
        .a_evt    (a_hit),
        .rise     (rise),
        .init_lvl (init_lvl),
        .pin_d    (pin_nx)
    );

    always_comb begin
        st_d     = st_q;
        restart  = clr_sel ? a_hit : p_hit;
        if (active) begin
            st_d.cnt = restart ? '0 : st_q.cnt + 1'b1;
        end
        st_d.fa  = (st_q.fa & ~flag_clr[0]) | a_hit;
        st_d.fp  = (st_q.fp & ~flag_clr[1]) | (p_hit & ~clr_sel);
        st_d.pin = pin_nx;
        st_d.run = run;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign flag_a  = st_q.fa;
    assign flag_p  = st_q.fp;
    assign pin_out = st_q.pin;
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic [1:0]    mode,
    input logic          clr_sel,
    input logic [1:0]    flag_clr,
    input logic [CW-1:0] count,
    input logic          flag_a,
    input logic          flag_p,
    input logic          pin_out
);
    assert_hold_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count));

    assert_hold_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(pin_out));

    assert_mode_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |=> $stable(count));

    assert_no_pflag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel && !flag_p) |=> !flag_p);

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == 2'b00) |=> (count == '0 || count == $past(count) + 1'b1));

    assert_sticky_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && !flag_clr[0]) |=> flag_a);

    assert_sticky_p_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_p && !flag_clr[1]) |=> flag_p);
endmodule

bind cmt_timer cmt_timer_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .mode     (mode),
    .clr_sel  (clr_sel),
    .flag_clr (flag_clr),
    .count    (count),
    .flag_a   (flag_a),
    .flag_p   (flag_p),
    .pin_out  (pin_out)
);

// File: tb/sim_cmt_timer.sv
module sim_cmt_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       run;
    logic [1:0] mode;
    logic       clr_sel;
    logic [1:0] pin_act;
    logic       init_lvl;
    logic [9:0] cmp_a;
    logic [2:0] cmp_p;
    logic [1:0] flag_clr;
    logic [9:0] count;
    logic       flag_a, flag_p, pin_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;
    string tag = "R1";

    logic [9:0] m_cnt;
    logic       m_fa, m_fp, m_pin, m_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmt_timer u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .clr_sel(clr_sel),
        .pin_act(pin_act), .init_lvl(init_lvl), .cmp_a(cmp_a), .cmp_p(cmp_p),
        .flag_clr(flag_clr), .count(count), .flag_a(flag_a), .flag_p(flag_p),
        .pin_out(pin_out)
    );

    function automatic logic [9:0] p_point(input logic [2:0] p);
        return (p == 3'd0) ? 10'h3FF : {p, 7'b0};
    endfunction

    function automatic logic pin_next(input logic pin, input logic [1:0] act);
        case (act)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~pin;
            default: return pin;
        endcase
    endfunction

    task automatic model_step();
        logic act_c, ah, ph, rs;
        act_c = run && (mode == 2'b00);
        ah    = act_c && (cmp_a != 10'd0) && (m_cnt == cmp_a);
        ph    = act_c && (m_cnt == p_point(cmp_p));
        rs    = run && !m_run;
        if (act_c) m_cnt = (clr_sel ? ah : ph) ? 10'd0 : m_cnt + 10'd1;
        m_fa  = (m_fa & ~flag_clr[0]) | ah;
        m_fp  = (m_fp & ~flag_clr[1]) | (ph & ~clr_sel);
        if (rs)      m_pin = init_lvl;
        else if (ah) m_pin = pin_next(m_pin, pin_act);
        m_run = run;
    endtask

    task automatic check1(input string what, input logic [9:0] got, input logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, got, exp, cycles);
        end
    endtask

    task automatic check_all();
        check1("count", count, m_cnt);
        check1("flag_a", {9'd0, flag_a}, {9'd0, m_fa});
        check1("flag_p", {9'd0, flag_p}, {9'd0, m_fp});
        check1("pin_out", {9'd0, pin_out}, {9'd0, m_pin});
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            check_all();
            flag_clr = 2'b00;
        end
    endtask

    task automatic set_cfg(input logic cs, input logic [9:0] a, input logic [2:0] p,
                           input logic [1:0] act);
        clr_sel = cs; cmp_a = a; cmp_p = p; pin_act = act;
    endtask

    task automatic restart_run(input logic lvl);
        run = 1'b0; cyc(2);
        init_lvl = lvl; run = 1'b1; cyc(1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; run = 1'b0; mode = 2'b00; flag_clr = 2'b00; init_lvl = 1'b0;
        set_cfg(1'b0, 10'd0, 3'd0, 2'b00);
        m_cnt = '0; m_fa = 0; m_fp = 0; m_pin = 0; m_run = 0;
        repeat (3) @(negedge clk);
        tag = "R1"; check_all();
        rst_n = 1'b1;
        @(negedge clk); check_all();

        // A-clear with toggle, enable starts pin high
        tag = "R5"; set_cfg(1'b1, 10'd5, 3'd0, 2'b11);
        init_lvl = 1'b1; run = 1'b1; cyc(1);
        tag = "R8"; check1("pin init high", {9'd0, pin_out}, 10'd1);
        tag = "R7"; cyc(30);
        // P value below A value, P flag must stay low
        tag = "R5"; set_cfg(1'b1, 10'd200, 3'd1, 2'b10);
        cyc(500);
        check1("flag_p stays low", {9'd0, flag_p}, 10'd0);
        // Zero A value: full-scale wrap without A flag
        tag = "R6"; flag_clr = 2'b11; set_cfg(1'b1, 10'd0, 3'd2, 2'b11);
        cyc(1100);
        check1("flag_a never set", {9'd0, flag_a}, 10'd0);
        // P clear, zero period value: wrap and P flag
        tag = "R4"; set_cfg(1'b0, 10'd40, 3'd0, 2'b01);
        restart_run(1'b1);
        cyc(1100);
        check1("flag_p set at wrap", {9'd0, flag_p}, 10'd1);
        tag = "R4"; set_cfg(1'b0, 10'd9, 3'd1, 2'b10);
        cyc(400);
        // Each pin action
        tag = "R7";
        for (int k = 0; k < 4; k++) begin
            set_cfg(1'b1, 10'd7, 3'd0, 2'(k));
            restart_run(k[0]);
            cyc(40);
        end
        // Run low hold, reserved mode freeze
        tag = "R2"; run = 1'b0; cyc(20);
        tag = "R3"; run = 1'b1; mode = 2'b10; cyc(20);
        check1("flags unset in reserved mode", {8'd0, flag_a, flag_p}, {8'd0, m_fa, m_fp});
        mode = 2'b00;
        // Clear versus set
        tag = "R9"; flag_clr = 2'b11; cyc(1);
        check1("flags cleared", {8'd0, flag_a, flag_p}, {8'd0, m_fa, m_fp});

        // Random stretches
        for (int blk = 0; blk < 40; blk++) begin
            tag = "R4";
            set_cfg(1'($urandom), ($urandom % 5 == 0) ? 10'd0 : 10'($urandom % 300),
                    3'($urandom), 2'($urandom));
            mode = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            for (int c = 0; c < 300; c++) begin
                if ($urandom % 50 == 0) run = ~run;
                if ($urandom % 20 == 0) flag_clr = 2'($urandom);
                init_lvl = 1'($urandom);
                cyc(1);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule